// File: doc/BRIEF.md
# Optical Monitor Configuration Target

This block is a two-wire serial (I2C) target that holds the configuration bytes of a light-monitoring front end. Bus traffic arrives on a clock and a data line. Both lines are sampled by a faster system clock. The target answers on the data line only by pulling it low through an open-drain enable. Each line passes through an optional glitch filter, and one control bit switches that filter off.

The device address has seven bits, `0 0 1 1 1 0 S`, where `S` is the strap input. A write carries the address byte with the write flag, then a register pointer, then data bytes. A read first sets the pointer with a write, then sends a repeated start and the address byte with the read flag. The target then returns bytes from the pointer. The pointer steps forward after every data byte in both directions, so bursts work.

The register file has fixed identification bytes and gain bytes with individual reset values. It also has three slow-tail compensation bytes, in which a cleared enable zeroes the other fields, and a transimpedance range byte. The full register image is brought out on a flat bus for the analog side to use.

Top module: `optmon_cfg_target`

## Requirements
- R1: Only the address `{6'b001110, addr_strap}` is acknowledged. A transaction sent to any other address gets no acknowledge on any byte and changes no register.
- R2: A write (address+W, pointer, data) is acknowledged on every byte, and the data byte lands in the register at the pointer.
- R3: A read (address+W, pointer, repeated start, address+R) returns the register at the pointer, most significant bit first.
- R4: Address 00h always reads 27h and address 01h always reads E0h. Writes to them are acknowledged and discarded.
- R5: After reset, 12h, 13h, 15h, 16h, 18h and 19h hold 7Fh, while 11h, 14h and 17h hold FFh. All other addresses below 20h except 00h and 01h hold 00h.
- R6: At 1Ah, 1Bh and 1Eh, bit 7 is the enable, bits 6:4 the time constant and bits 2:0 the magnitude, and bit 3 always reads 0. A write with bit 7 = 0 stores 00h.
- R7: At 1Ch only bits 3:0 (two 2-bit range selects) are kept, and bits 7:4 read 0.
- R8: Addresses 02h–0Fh, 1Dh, 1Fh and everything from 20h up read 00h. Writes to them are acknowledged and discarded.
- R9: The pointer increments after each data byte, so multi-byte writes and reads touch consecutive addresses.
- R10: When bit 6 of register 10h is 0, a pulse shorter than `FILT_CYC` system clocks on either bus line has no effect on the transaction. When that bit is 1, the lines are used unfiltered.
- R11: The register image changes only in the cycle after an accepted data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset, restores all defaults |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_strap | input | 1 | Lowest device-address bit (0 when unconnected) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| cfg_image | output | NREG*8 | All register bytes, address n at bits [8n+7:8n] |

## Verification
The bench builds the target with `FILT_CYC = 3` and `NREG = 32`. This keeps the glitch threshold just above the two-cycle pulses the bench injects. The full address space below 20h, plus some addresses above it, fits within one random sweep. With a filter of 3, a two-cycle pulse on the clock line between bits, or on the data line while the clock is high, must leave a write intact. The same data-line pulse with the filter bypassed must read as a start and stop and abort the write. The random sweep also reaches the slow-tail clearing rule and the discard paths, and the strap value is toggled to move the device address.

// File: rtl/optmon_cfg_pkg.sv
// Package: register map rules and shared types for the optical monitor
// configuration target. Assumes a map of at least 32 byte addresses.
package optmon_cfg_pkg;

    localparam int CTRL_ADDR    = 16;   // control byte
    localparam int DEGLITCH_BIT = 6;    // 1 = bypass bus-line filter

    typedef enum logic [2:0] {
        K_RSVD, K_ID, K_RW, K_TAIL, K_TIA
    } reg_kind_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_DEV, PH_PTR, PH_WDAT, PH_RDAT
    } phase_t;

    // Classify an address
    function automatic reg_kind_t kind_of(input int a);
        case (a)
            0, 1:                                   kind_of = K_ID;
            16, 17, 18, 19, 20, 21, 22, 23, 24, 25: kind_of = K_RW;
            26, 27, 30:                             kind_of = K_TAIL;
            28:                                     kind_of = K_TIA;
            default:                                kind_of = K_RSVD;
        endcase
    endfunction

    // Power-on value of an address
    function automatic logic [7:0] reset_of(input int a);
        case (a)
            0:                       reset_of = 8'h27;
            1:                       reset_of = 8'hE0;
            17, 20, 23:              reset_of = 8'hFF;
            18, 19, 21, 22, 24, 25:  reset_of = 8'h7F;
            default:                 reset_of = 8'h00;
        endcase
    endfunction

    // Whether a bus write may change an address
    function automatic bit writable(input int a);
        writable = (kind_of(a) == K_RW) || (kind_of(a) == K_TAIL) ||
                   (kind_of(a) == K_TIA);
    endfunction

    // Value stored for a written byte, applying per-kind side effects
    function automatic logic [7:0] shape_write(input int a, input logic [7:0] d);
        case (kind_of(a))
            K_TAIL:  shape_write = d[7] ? {d[7:4], 1'b0, d[2:0]} : 8'h00;
            K_TIA:   shape_write = {4'h0, d[3:0]};
            default: shape_write = d;
        endcase
    endfunction

endpackage

// File: rtl/optmon_line_filter.sv
// Module: two-flop synchronizer plus persistence filter for one bus line.
// The filtered output follows the input only after FILT_CYC consecutive
// cycles of a new value; bypass selects the synchronized line directly.
// Assumes FILT_CYC >= 1. Idle level of the line is 1.
module optmon_line_filter #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw};
    end

    // Accept a new level only after it has persisted for FILT_CYC cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (sync_q[1] != filt_q) begin
            if (cnt_q == CW'(FILT_CYC - 1)) begin
                filt_q <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign clean = bypass ? sync_q[1] : filt_q;
endmodule

// File: rtl/optmon_cfg_regs.sv
// Module: configuration register file. One byte per address, each with its
// own reset value; only writable kinds accept wr_en. Reads beyond NREG
// return 00h. Assumes NREG is a power of two between 32 and 128.
module optmon_cfg_regs
    import optmon_cfg_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] image
);
    localparam int IDX_W = $clog2(NREG);

    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (writable(g)) begin : g_rw
            // Hold one writable byte with its reset value
            always_ff @(posedge clk) begin
                if (!rst_n)                           regs[g] <= reset_of(g);
                else if (wr_en && wr_addr == 8'(g))   regs[g] <= shape_write(g, wr_data);
            end
        end else begin : g_ro
            assign regs[g] = reset_of(g);
        end
        assign image[g*8 +: 8] = regs[g];
    end

    // Return the addressed byte, 00h outside the map
    always_comb begin
        if (rd_addr < 8'(NREG)) rd_data = regs[rd_addr[IDX_W-1:0]];
        else                    rd_data = 8'h00;
    end
endmodule

// File: rtl/optmon_i2c_engine.sv
// Module: byte-level two-wire target state machine. Works on filtered,
// synchronized line copies; detects start/stop and clock edges from one
// registered copy. Acknowledges the matching address, pointer and data
// bytes; drives read data MSB first and steps the pointer per byte.
module optmon_i2c_engine
    import optmon_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic       strap,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    phase_t     phase;
    logic       scl_q, sda_q;
    logic [3:0] bitcnt;
    logic [7:0] rx_sh, tx_sh;
    logic       in_ack, ack_oe, tx_en, load_pend, rw, m_ack;

    wire scl_rise = scl & ~scl_q;
    wire scl_fall = ~scl & scl_q;
    wire start_ev = scl & scl_q & sda_q & ~sda;
    wire stop_ev  = scl & scl_q & ~sda_q & sda;
    wire rx_phase = (phase == PH_DEV) || (phase == PH_PTR) || (phase == PH_WDAT);

    // Keep previous line levels for edge and condition detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Sequence the transaction: receive, acknowledge, transmit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;  bitcnt <= '0;  rx_sh <= '0;  tx_sh <= '0;
            in_ack <= 1'b0;    ack_oe <= 1'b0; tx_en <= 1'b0; load_pend <= 1'b0;
            rw <= 1'b0;        m_ack <= 1'b0;  ptr <= '0;
            wr_en <= 1'b0;     wr_addr <= '0;  wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                phase <= PH_DEV;  bitcnt <= '0;  in_ack <= 1'b0;
                ack_oe <= 1'b0;   tx_en <= 1'b0; load_pend <= 1'b0;
            end else if (stop_ev) begin
                phase <= PH_IDLE; in_ack <= 1'b0; ack_oe <= 1'b0;
                tx_en <= 1'b0;    load_pend <= 1'b0;
            end else begin
                if (load_pend) begin
                    tx_sh     <= rd_data;
                    tx_en     <= 1'b1;
                    load_pend <= 1'b0;
                end
                if (scl_rise) begin
                    if (rx_phase && !in_ack && bitcnt < 4'd8) begin
                        rx_sh  <= {rx_sh[6:0], sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (phase == PH_RDAT) begin
                        if (bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
                        else if (bitcnt == 4'd8) begin
                            m_ack  <= ~sda;
                            bitcnt <= 4'd9;
                        end
                    end
                end
                if (scl_fall) begin
                    if (rx_phase && in_ack) begin
                        in_ack <= 1'b0;
                        ack_oe <= 1'b0;
                        bitcnt <= '0;
                        if (phase == PH_DEV) begin
                            if (rw) begin
                                phase     <= PH_RDAT;
                                load_pend <= 1'b1;
                            end else begin
                                phase <= PH_PTR;
                            end
                        end else begin
                            phase <= PH_WDAT;
                        end
                    end else if (rx_phase && bitcnt == 4'd8) begin
                        if (phase == PH_DEV) begin
                            if (rx_sh[7:1] == {6'b001110, strap}) begin
                                in_ack <= 1'b1;
                                ack_oe <= 1'b1;
                                rw     <= rx_sh[0];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            in_ack <= 1'b1;
                            ack_oe <= 1'b1;
                            if (phase == PH_PTR) begin
                                ptr <= rx_sh;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= rx_sh;
                                ptr     <= ptr + 8'd1;
                            end
                        end
                    end else if (phase == PH_RDAT) begin
                        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                            tx_sh <= {tx_sh[6:0], 1'b0};
                        end else if (bitcnt == 4'd8) begin
                            tx_en <= 1'b0;
                        end else if (bitcnt == 4'd9) begin
                            if (m_ack) begin
                                ptr       <= ptr + 8'd1;
                                load_pend <= 1'b1;
                                bitcnt    <= '0;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                end
            end
        end
    end

    assign sda_oe = ack_oe | (tx_en & ~tx_sh[7]);
endmodule

// File: rtl/optmon_cfg_target.sv
// Module: top of the optical monitor configuration target. Filters both
// bus lines (bypassable from the control byte), runs the byte engine and
// holds the register file. Assumes clk is at least ~20x the bus clock.
module optmon_cfg_target
    import optmon_cfg_pkg::*;
#(
    parameter int FILT_CYC = 3,
    parameter int NREG     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_strap,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_image
);
    logic [1:0] raw_lines, clean_lines;
    logic       bypass;
    logic [7:0] ptr, rd_data, eng_wr_addr, eng_wr_data;
    logic       eng_wr_en;

    assign raw_lines = {sda_i, scl_i};
    assign bypass    = cfg_image[CTRL_ADDR*8 + DEGLITCH_BIT];

    for (genvar l = 0; l < 2; l++) begin : g_line
        optmon_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .bypass (bypass),
            .raw    (raw_lines[l]),
            .clean  (clean_lines[l])
        );
    end

    optmon_i2c_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (clean_lines[0]),
        .sda     (clean_lines[1]),
        .strap   (addr_strap),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr_en   (eng_wr_en),
        .wr_addr (eng_wr_addr),
        .wr_data (eng_wr_data),
        .sda_oe  (sda_oe)
    );

    optmon_cfg_regs #(.NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (eng_wr_en),
        .wr_addr (eng_wr_addr),
        .wr_data (eng_wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .image   (cfg_image)
    );
endmodule

// File: rtl/optmon_cfg_checker.sv
// Module: property checker for the configuration target, bound to the top.
// Observes the engine's write strobe and the register image.
module optmon_cfg_checker #(
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [NREG*8-1:0] image
);
    // R11: image moves only after a write strobe
    a_r11_image_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(image));

    // R4: identification bytes survive writes
    a_r4_id_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr <= 8'd1) |=> (image[15:0] == 16'hE027));

    // R6: cleared enable means zero fields, bit 3 always zero
    a_r6_tail_red: assert property (@(posedge clk) disable iff (!rst_n)
        !image[26*8+7] |-> (image[26*8 +: 7] == 7'd0));
    a_r6_tail_grn: assert property (@(posedge clk) disable iff (!rst_n)
        !image[27*8+7] |-> (image[27*8 +: 7] == 7'd0));
    a_r6_tail_blu: assert property (@(posedge clk) disable iff (!rst_n)
        !image[30*8+7] |-> (image[30*8 +: 7] == 7'd0));
    a_r6_tail_bit3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (image[26*8+3] == 1'b0 && image[27*8+3] == 1'b0 &&
                   image[30*8+3] == 1'b0));

    // R7: upper nibble of the range byte stays zero after a write
    a_r7_tia_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h1C) |=> (image[28*8+4 +: 4] == 4'h0));

    // R8: reserved slot inside the map ignores writes
    a_r8_rsvd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h1D) |=> (image[29*8 +: 8] == 8'h00));
endmodule

bind optmon_cfg_target optmon_cfg_checker #(.NREG(NREG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (eng_wr_en),
    .wr_addr (eng_wr_addr),
    .image   (cfg_image)
);

// File: tb/optmon_cfg_target_bench.sv
// Bench: drives the two-wire bus as a master, keeps a reference model of
// the register file, and compares reads, acknowledges and the image.
module optmon_cfg_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FILT_CYC   = 3;
    localparam int NREG       = 32;
    localparam int Q          = 10;   // system clocks per bus quarter

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_image;
    wire  sda_line = sda_m & ~sda_oe;

    int nchk = 0, nerr = 0;
    logic [7:0] mdl [NREG];
    logic [7:0] bbuf [8];
    logic [7:0] rbuf [40];

    always #(CLK_PERIOD/2) clk = ~clk;

    optmon_cfg_target #(.FILT_CYC(FILT_CYC), .NREG(NREG)) u_optmon_cfg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_strap(strap), .sda_oe(sda_oe), .cfg_image(cfg_image)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic logic [7:0] m_reset(input int a);
        if (a == 0) return 8'h27;
        if (a == 1) return 8'hE0;
        if (a == 17 || a == 20 || a == 23) return 8'hFF;
        if (a == 18 || a == 19 || a == 21 || a == 22 || a == 24 || a == 25) return 8'h7F;
        return 8'h00;
    endfunction

    function automatic logic [7:0] m_store(input int a, input logic [7:0] d, input logic [7:0] old);
        if (a >= 16 && a <= 25) return d;
        if (a == 26 || a == 27 || a == 30) return d[7] ? (d & 8'hF7) : 8'h00;
        if (a == 28) return d & 8'h0F;
        return old;
    endfunction

    function automatic logic [7:0] m_read(input int a);
        if (a < NREG) return mdl[a];
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_image(input string req);
        for (int a = 0; a < NREG; a++)
            check(cfg_image[a*8 +: 8] == mdl[a], req, cfg_image[a*8 +: 8], mdl[a]);
    endtask

    // ---------------- bus primitives ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    // glitch: 0 none, 1 short scl pulse in low phase, 2 short sda dip while scl high
    task automatic send_byte(input logic [7:0] b, input int glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1;
            if (glitch == 2 && i == 7) begin
                tick(Q/2); sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(Q/2 - 2);
            end else begin
                tick(Q);
            end
            scl_m = 1'b0;
            if (glitch == 1 && i == 4) begin
                tick(Q/2); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q/2 - 2);
            end else begin
                tick(Q);
            end
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2);
        ack = ~sda_line;
        tick(Q/2); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q/2);
            b[i] = sda_line;
            tick(Q/2); scl_m = 1'b0;
        end
        tick(Q/2); sda_m = give_ack ? 1'b0 : 1'b1; tick(Q/2);
        scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
    endtask

    // write n bytes of bbuf starting at ptr; acks collects each byte's ack
    task automatic do_write(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                            input int glitch, output bit all_ack, output bit any_ack);
        bit a;
        all_ack = 1'b1; any_ack = 1'b0;
        bus_start();
        send_byte({dev, 1'b0}, 0, a); all_ack &= a; any_ack |= a;
        send_byte(ptr, 0, a);         all_ack &= a; any_ack |= a;
        for (int i = 0; i < n; i++) begin
            send_byte(bbuf[i], glitch, a); all_ack &= a; any_ack |= a;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [7:0] ptr, input int n, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        bus_start();
        send_byte({dev, 1'b0}, 0, a); all_ack &= a;
        send_byte(ptr, 0, a);         all_ack &= a;
        bus_start();
        send_byte({dev, 1'b1}, 0, a); all_ack &= a;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    // model update for a burst write that the target accepts
    task automatic model_burst(input logic [7:0] ptr, input int n);
        for (int i = 0; i < n; i++) begin
            int a = int'(8'(ptr + 8'(i)));
            if (a < NREG) mdl[a] = m_store(a, bbuf[i], mdl[a]);
        end
    endtask

    localparam logic [6:0] DEV0 = 7'h1C;
    localparam logic [6:0] DEV1 = 7'h1D;

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual 00 expected 01");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        bit aa, an;
        logic [7:0] ad, dd;
        void'($urandom(32'h0F7C_5EED));
        for (int a = 0; a < NREG; a++) mdl[a] = m_reset(a);
        tick(5); rst_n = 1'b1; tick(5);

        // R5 reset image; reset sda_oe released
        check_image("R5 reset value");
        check(sda_oe == 1'b0, "R5 sda released after reset", {7'd0, sda_oe}, 8'h00);

        // R3 R9 R4 R8 burst read of the whole map
        do_read(DEV0, 8'h00, 34, aa);
        check(aa, "R3 read acks", {7'd0, aa}, 8'h01);
        for (int a = 0; a < 34; a++)
            check(rbuf[a] == m_read(a), "R9 burst read", rbuf[a], m_read(a));

        // R2 R3 constrained random writes with readback
        for (int it = 0; it < 24; it++) begin
            ad = 8'($urandom_range(0, 40));
            dd = 8'($urandom);
            if (ad == 8'h10) dd[6] = 1'b0;   // keep filter active here
            bbuf[0] = dd;
            do_write(DEV0, ad, 1, 0, aa, an);
            check(aa, "R2 write acks", {7'd0, aa}, 8'h01);
            model_burst(ad, 1);
            do_read(DEV0, ad, 1, aa);
            check(rbuf[0] == m_read(int'(ad)), "R2 R3 readback", rbuf[0], m_read(int'(ad)));
        end
        check_image("R2 image after random writes");

        // R6 slow-tail clearing and bit 3
        bbuf[0] = 8'h7F; bbuf[1] = 8'hFF;
        do_write(DEV0, 8'h1A, 2, 0, aa, an); model_burst(8'h1A, 2);
        check(cfg_image[26*8 +: 8] == 8'h00, "R6 enable clear zeroes fields", cfg_image[26*8 +: 8], 8'h00);
        check(cfg_image[27*8 +: 8] == 8'hF7, "R6 bit3 reads zero", cfg_image[27*8 +: 8], 8'hF7);
        bbuf[0] = 8'hAD; do_write(DEV0, 8'h1E, 1, 0, aa, an); model_burst(8'h1E, 1);
        do_read(DEV0, 8'h1E, 1, aa);
        check(rbuf[0] == 8'hA5, "R6 blue tail", rbuf[0], 8'hA5);

        // R7 range byte masking
        bbuf[0] = 8'hFF; do_write(DEV0, 8'h1C, 1, 0, aa, an); model_burst(8'h1C, 1);
        do_read(DEV0, 8'h1C, 1, aa);
        check(rbuf[0] == 8'h0F, "R7 range byte", rbuf[0], 8'h0F);

        // R4 ID write discarded but acked
        bbuf[0] = 8'h55; bbuf[1] = 8'h55;
        do_write(DEV0, 8'h00, 2, 0, aa, an);
        check(aa, "R4 ID write acked", {7'd0, aa}, 8'h01);
        do_read(DEV0, 8'h00, 2, aa);
        check(rbuf[0] == 8'h27, "R4 ID0", rbuf[0], 8'h27);
        check(rbuf[1] == 8'hE0, "R4 ID1", rbuf[1], 8'hE0);

        // R8 reserved addresses
        bbuf[0] = 8'hAA; do_write(DEV0, 8'h1D, 1, 0, aa, an);
        check(aa, "R8 reserved write acked", {7'd0, aa}, 8'h01);
        do_read(DEV0, 8'h1D, 1, aa);
        check(rbuf[0] == 8'h00, "R8 reserved 1Dh", rbuf[0], 8'h00);
        do_read(DEV0, 8'h40, 1, aa);
        check(rbuf[0] == 8'h00, "R8 reserved 40h", rbuf[0], 8'h00);

        // R1 wrong address and strap
        bbuf[0] = 8'h11; do_write(DEV1, 8'h12, 1, 0, aa, an);
        check(!an, "R1 foreign address not acked", {7'd0, an}, 8'h00);
        check_image("R1 no change on foreign address");
        strap = 1'b1;
        bbuf[0] = 8'h22; do_write(DEV1, 8'h12, 1, 0, aa, an); model_burst(8'h12, 1);
        check(aa, "R1 strap address acked", {7'd0, aa}, 8'h01);
        bbuf[0] = 8'h33; do_write(DEV0, 8'h12, 1, 0, aa, an);
        check(!an, "R1 old address rejected", {7'd0, an}, 8'h00);
        check_image("R1 strap image");
        strap = 1'b0;

        // R9 burst write spanning several kinds
        for (int i = 0; i < 6; i++) bbuf[i] = 8'($urandom);
        do_write(DEV0, 8'h17, 6, 0, aa, an); model_burst(8'h17, 6);
        check_image("R9 burst write");

        // R10 glitches rejected with the filter on
        bbuf[0] = 8'hC6; do_write(DEV0, 8'h13, 1, 1, aa, an); model_burst(8'h13, 1);
        check(cfg_image[19*8 +: 8] == 8'hC6, "R10 scl glitch filtered", cfg_image[19*8 +: 8], 8'hC6);
        bbuf[0] = 8'hA5; do_write(DEV0, 8'h15, 1, 2, aa, an); model_burst(8'h15, 1);
        check(cfg_image[21*8 +: 8] == 8'hA5, "R10 sda glitch filtered", cfg_image[21*8 +: 8], 8'hA5);

        // R10 bypass: same sda dip becomes start+stop and aborts the write
        bbuf[0] = 8'h40; do_write(DEV0, 8'h10, 1, 0, aa, an); model_burst(8'h10, 1);
        bbuf[0] = 8'h9B; do_write(DEV0, 8'h16, 1, 2, aa, an);
        check(cfg_image[22*8 +: 8] == mdl[22], "R10 bypass glitch aborts", cfg_image[22*8 +: 8], mdl[22]);
        do_read(DEV0, 8'h10, 1, aa);
        check(rbuf[0] == 8'h40, "R10 bypass normal read", rbuf[0], 8'h40);
        check_image("R11 final image");

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule